// File: doc/BRIEF.md
# DMA End-Pointer Address Generator

This block produces the source read address and destination write address for every beat of one DMA channel's transfer cycle. Software programs two end pointers, which are the addresses of the final beat on each side. It also programs a 2-bit stride code per side, a direction bit per side, and a remaining-beat count. Each address is derived backward from its end pointer: the remaining count is scaled by the stride and subtracted from the pointer. When the side walks downward, the scaled count is added instead. The block therefore reaches exactly the end pointer on the beat issued at count zero.

A `start` pulse loads the configuration and the initial count. The count comes from bits [13:4] of `cfg_word`. The generator then holds `busy` high and presents both addresses until the consumer accepts each beat with `beat_ready`. After the final beat, `done` pulses for one cycle. A bus error stops the cycle and freezes the remaining count, so software can work out how many beats completed. If byte swap is requested together with either direction bit, the start is refused and `config_error` is raised.

Top module: `dma_endptr_agen`

## Requirements
- R1: After reset, `busy`, `done`, `config_error` and `remaining` are all zero.
- R2: A `start` seen while idle with a legal configuration sets `busy` on the next cycle and loads `remaining` from `cfg_word[13:4]`. Both addresses for the first beat appear in that same cycle.
- R3: With direction bit 0 and stride code 0, 1 or 2 (strides of 1, 2 and 4 bytes), the address is the end pointer minus (`remaining` << code).
- R4: With direction bit 1 and stride code 0, 1 or 2, the address is the end pointer plus (`remaining` << code). Each side takes its own direction bit, so all four direction combinations work.
- R5: Stride code 3 holds that side's address at the end pointer for every beat.
- R6: The beat presented at `remaining` = 0 uses exactly the end pointer on both sides, in every mode.
- R7: Each accepted beat (`busy` and `beat_ready` high, `bus_err` low) lowers `remaining` by one and updates the addresses. When the beat at count zero is accepted, `busy` drops and `done` is high for exactly the next cycle.
- R8: `beat_ready` has no effect while idle, and `start` has no effect while busy.
- R9: A `start` seen while idle with `byte_swap` and either direction bit set is refused: `busy` stays low and `config_error` goes high. `config_error` holds until the next `start` seen while idle with a legal configuration clears it.
- R10: `bus_err` while busy ends the cycle without a `done` pulse and leaves `remaining` at the count of the beat then on offer. `bus_err` takes priority over `beat_ready`.
- R11: Address arithmetic wraps modulo 2^32, with no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer cycle |
| cfg_word | input | 32 | Channel configuration word; bits [13:4] hold the beat count minus one |
| src_end | input | 32 | Source end pointer |
| dst_end | input | 32 | Destination end pointer |
| src_inc | input | 2 | Source stride code (0/1/2 = 1/2/4 bytes, 3 = fixed) |
| dst_inc | input | 2 | Destination stride code |
| src_dec | input | 1 | Source direction: 1 = addresses fall toward the end pointer from above |
| dst_dec | input | 1 | Destination direction |
| byte_swap | input | 1 | Byte swap requested for this channel |
| beat_ready | input | 1 | Current beat accepted |
| bus_err | input | 1 | Bus error on the current beat |
| busy | output | 1 | Cycle in progress; addresses valid |
| src_addr | output | 32 | Source read address of the current beat |
| dst_addr | output | 32 | Destination write address of the current beat |
| remaining | output | 10 | Beats left minus one |
| done | output | 1 | One-cycle pulse after the last beat |
| config_error | output | 1 | Last start refused for byte swap with a direction bit set |

## Verification
The bench runs every pairing of stride code and direction, and checks that the last beat lands on the end pointer. A design that inverted the sign, or scaled by the wrong shift, would miss the end pointer or move by the wrong stride. Runs that start near zero and near 2^32 catch a design that saturates instead of wrapping. Idle `beat_ready` pulses and a mid-cycle `start` catch a design that lets either one disturb the count. A bus error after two beats, and a refused byte-swap start, expose a design that pulses `done` on abort, loses the frozen count, or starts anyway.

// File: rtl/dma_endptr_agen.sv
module dma_endptr_agen #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 10,
  parameter int CNT_LSB = 4,
  parameter int CFG_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [ADDR_W-1:0] src_end,
  input  logic [ADDR_W-1:0] dst_end,
  input  logic [1:0]        src_inc,
  input  logic [1:0]        dst_inc,
  input  logic              src_dec,
  input  logic              dst_dec,
  input  logic              byte_swap,
  input  logic              beat_ready,
  input  logic              bus_err,
  output logic              busy,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [CNT_W-1:0]  remaining,
  output logic              done,
  output logic              config_error
);

  function automatic logic [ADDR_W-1:0] addr_at(input logic [ADDR_W-1:0] ep,
                                                input logic [CNT_W-1:0]  n,
                                                input logic [1:0]        inc,
                                                input logic              dec);
    logic [ADDR_W-1:0] off;
    off = ADDR_W'(n) << inc;
    if (inc == 2'd3) return ep;
    else if (dec)    return ep + off;
    else             return ep - off;
  endfunction

  logic              busy_q, done_q, cerr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] sep_q, dep_q, saddr_q, daddr_q;
  logic [1:0]        sinc_q, dinc_q;
  logic              sdec_q, ddec_q;

  wire              illegal = byte_swap & (src_dec | dst_dec);
  wire              go      = start & ~busy_q & ~illegal;
  wire              step    = busy_q & beat_ready & ~bus_err;
  wire              last    = step & (cnt_q == '0);
  wire [CNT_W-1:0]  cnt_ld  = cfg_word[CNT_LSB +: CNT_W];
  wire [CNT_W-1:0]  cnt_nx  = cnt_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cerr_q  <= 1'b0;
      cnt_q   <= '0;
      sep_q   <= '0;
      dep_q   <= '0;
      sinc_q  <= '0;
      dinc_q  <= '0;
      sdec_q  <= 1'b0;
      ddec_q  <= 1'b0;
      saddr_q <= '0;
      daddr_q <= '0;
    end else begin
      done_q <= last;
      if (start && !busy_q) cerr_q <= illegal;
      if (go) begin
        busy_q  <= 1'b1;
        cnt_q   <= cnt_ld;
        sep_q   <= src_end;
        dep_q   <= dst_end;
        sinc_q  <= src_inc;
        dinc_q  <= dst_inc;
        sdec_q  <= src_dec;
        ddec_q  <= dst_dec;
        saddr_q <= addr_at(src_end, cnt_ld, src_inc, src_dec);
        daddr_q <= addr_at(dst_end, cnt_ld, dst_inc, dst_dec);
      end else if (busy_q && bus_err) begin
        busy_q <= 1'b0;
      end else if (last) begin
        busy_q <= 1'b0;
      end else if (step) begin
        cnt_q   <= cnt_nx;
        saddr_q <= addr_at(sep_q, cnt_nx, sinc_q, sdec_q);
        daddr_q <= addr_at(dep_q, cnt_nx, dinc_q, ddec_q);
      end
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign config_error = cerr_q;
  assign remaining    = cnt_q;
  assign src_addr     = saddr_q;
  assign dst_addr     = daddr_q;

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !illegal) |=> (busy && remaining == $past(cnt_ld)));

  p_fixed_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sinc_q == 2'd3) |-> (src_addr == sep_q));

  p_last_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && remaining == '0) |-> (src_addr == sep_q && dst_addr == dep_q));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && beat_ready && !bus_err && remaining != '0) |=> (busy && remaining == $past(remaining) - 1'b1));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(remaining) && !busy));

  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && illegal) |=> (!busy && config_error));

  p_abort_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_err) |=> (!busy && !done && remaining == $past(remaining)));

endmodule

// File: tb/dma_endptr_agen_tb_top.sv
`timescale 1ns/100ps
module dma_endptr_agen_tb_top;

  typedef struct {
    logic [31:0] s;
    logic [31:0] d;
    logic [9:0]  n;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [31:0] src_end = '0, dst_end = '0;
  logic [1:0]  src_inc = '0, dst_inc = '0;
  logic        src_dec = 1'b0, dst_dec = 1'b0, byte_swap = 1'b0;
  logic        beat_ready = 1'b0, bus_err = 1'b0;
  logic        busy, done, config_error;
  logic [31:0] src_addr, dst_addr;
  logic [9:0]  remaining;

  int checks = 0;
  int fails  = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  dma_endptr_agen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word),
    .src_end(src_end), .dst_end(dst_end), .src_inc(src_inc), .dst_inc(dst_inc),
    .src_dec(src_dec), .dst_dec(dst_dec), .byte_swap(byte_swap),
    .beat_ready(beat_ready), .bus_err(bus_err), .busy(busy),
    .src_addr(src_addr), .dst_addr(dst_addr), .remaining(remaining),
    .done(done), .config_error(config_error)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] ep, input int n,
                                        input logic [1:0] inc, input logic dec);
    logic [31:0] off;
    if (inc == 2'd3) return ep;
    off = 32'(n) * (32'd1 << inc);
    return dec ? ep + off : ep - off;
  endfunction

  always @(negedge clk) begin
    if (rst_n && busy && beat_ready && !bus_err) begin
      if (sb.size() == 0) begin
        check(1'b0, "R7", remaining, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(src_addr == e.s, e.tag, src_addr, e.s);
        check(dst_addr == e.d, e.tag, dst_addr, e.d);
        check(remaining == e.n, "R7", remaining, e.n);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic setup(input logic [31:0] se, input logic [31:0] de,
                       input logic [1:0] si, input logic [1:0] di,
                       input logic sd, input logic dd, input int n);
    src_end = se; dst_end = de; src_inc = si; dst_inc = di;
    src_dec = sd; dst_dec = dd; byte_swap = 1'b0;
    cfg_word = 32'hA000_0003 | (32'(n) << 4);
  endtask

  task automatic run(input logic [31:0] se, input logic [31:0] de,
                     input logic [1:0] si, input logic [1:0] di,
                     input logic sd, input logic dd, input int n,
                     input string tag, input bit poke);
    exp_t e;
    setup(se, de, si, di, sd, dd, n);
    for (int k = n; k >= 0; k--) begin
      e.s = model(se, k, si, sd);
      e.d = model(de, k, di, dd);
      e.n = 10'(k);
      e.tag = (k == 0) ? "R6" : tag;
      sb.push_back(e);
    end
    start = 1'b1;
    tick();
    start = 1'b0;
    check(busy == 1'b1, "R2", busy, 1);
    check(remaining == 10'(n), "R2", remaining, n);
    beat_ready = 1'b1;
    if (poke) begin
      cfg_word = 32'h0000_0070;
      src_end = 32'hDEAD_0000;
      start = 1'b1;
      tick();
      start = 1'b0;
      beat_ready = 1'b0;
      tick();
      beat_ready = 1'b1;
    end
    while (busy) tick();
    beat_ready = 1'b0;
    check(done == 1'b1, "R7", done, 1);
    check(sb.size() == 0, "R7", sb.size(), 0);
    tick();
    check(done == 1'b0, "R7", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check(busy == 1'b0 && done == 1'b0 && config_error == 1'b0, "R1", {busy, done, config_error}, 0);
    check(remaining == '0, "R1", remaining, 0);
    rst_n = 1'b1;
    tick();

    run(32'h0000_1000, 32'h0000_2000, 2'd2, 2'd0, 1'b0, 1'b0, 3, "R3", 1'b0);
    run(32'h0000_4002, 32'h0000_8010, 2'd1, 2'd1, 1'b0, 1'b0, 5, "R3", 1'b0);
    run(32'h0000_1000, 32'h0000_2000, 2'd2, 2'd1, 1'b1, 1'b0, 4, "R4", 1'b0);
    run(32'h0000_1000, 32'h0000_2000, 2'd0, 2'd2, 1'b0, 1'b1, 4, "R4", 1'b0);
    run(32'h0000_3000, 32'h0000_5000, 2'd1, 2'd2, 1'b1, 1'b1, 6, "R4", 1'b0);
    run(32'h0000_7777, 32'h0000_9000, 2'd3, 2'd0, 1'b0, 1'b0, 4, "R5", 1'b0);
    run(32'h0000_9000, 32'h0000_7777, 2'd2, 2'd3, 1'b1, 1'b1, 3, "R5", 1'b0);
    run(32'h0000_0010, 32'hFFFF_FFF0, 2'd2, 2'd2, 1'b0, 1'b1, 10, "R11", 1'b0);
    run(32'h0000_0000, 32'h0000_0100, 2'd0, 2'd0, 1'b0, 1'b0, 0, "R6", 1'b0);
    run(32'h0000_6000, 32'h0000_6800, 2'd2, 2'd2, 1'b0, 1'b0, 4, "R8", 1'b1);

    begin : abort_case
      exp_t e;
      setup(32'h0000_1000, 32'h0000_2000, 2'd2, 2'd2, 1'b0, 1'b0, 5);
      for (int k = 5; k >= 4; k--) begin
        e.s = model(32'h0000_1000, k, 2'd2, 1'b0);
        e.d = model(32'h0000_2000, k, 2'd2, 1'b0);
        e.n = 10'(k);
        e.tag = "R10";
        sb.push_back(e);
      end
      start = 1'b1;
      tick();
      start = 1'b0;
      beat_ready = 1'b1;
      tick();
      tick();
      bus_err = 1'b1;
      tick();
      bus_err = 1'b0;
      beat_ready = 1'b0;
      check(busy == 1'b0, "R10", busy, 0);
      check(done == 1'b0, "R10", done, 0);
      check(remaining == 10'd3, "R10", remaining, 3);
      check(sb.size() == 0, "R10", sb.size(), 0);
      beat_ready = 1'b1;
      tick();
      tick();
      beat_ready = 1'b0;
      tick();
      check(remaining == 10'd3 && busy == 1'b0, "R8", remaining, 3);
    end

    setup(32'h0000_1000, 32'h0000_2000, 2'd0, 2'd0, 1'b1, 1'b0, 4);
    byte_swap = 1'b1;
    start = 1'b1;
    tick();
    start = 1'b0;
    byte_swap = 1'b0;
    check(busy == 1'b0, "R9", busy, 0);
    check(config_error == 1'b1, "R9", config_error, 1);
    check(remaining == 10'd3, "R9", remaining, 3);
    tick();
    check(config_error == 1'b1, "R9", config_error, 1);
    run(32'h0000_1000, 32'h0000_2000, 2'd0, 2'd0, 1'b0, 1'b0, 2, "R3", 1'b0);
    check(config_error == 1'b0, "R9", config_error, 0);

    repeat (2) tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule